// File: doc/BRIEF.md
# Wake Output Signal Generator

This block turns an internal power-management wake event into two host-facing signals. The first is an active-low, open-drain style event request. It is modelled as a drive-low enable: 1 pulls the line low, 0 releases it. The request stays pending until the host acknowledges it with a clear strobe.

The second signal is a LAN wake output. Its polarity and shape come from a registered 2-bit mode field: a high level, a low level, a positive pulse or a negative pulse. A gating input selects how the wake output relates to the request. With gating off, the wake output follows the request. With gating on, the wake output is active only while the request is pending and the active-low isolate input is low, which means main power is off.

While isolate is low, the block also blocks the enable of its other host-bus drivers. The event request is exempt from this and keeps working. Detecting magic packets and wake frames is done elsewhere.

Top module: `wol_wake_gen`

## Requirements
- R1: After reset, pme_drive_o is 0, lwake_o is 0, and the stored mode is the high-level style (00).
- R2: A high wake_evt_i at a clock edge sets the pending request, so pme_drive_o is 1 after that edge. A high clear_i alone clears it at the next edge. When both are high at the same edge, the event wins.
- R3: With gate_iso_i = 0, lwake_o goes active in the same cycle that pme_drive_o goes high.
- R4: With gate_iso_i = 1, lwake_o is active only while pme_drive_o is 1 and iso_ni is 0. Otherwise it sits at the mode's idle level.
- R5: The mode encodings are:
  - 00: high level (idle 0).
  - 01: low level (idle 1).
  - 10: positive pulse (idle 0).
  - 11: negative pulse (idle 1).
- R6: In either pulse mode, lwake_o is active for exactly PULSE_CYCLES cycles and then returns to idle, even while the request is still pending. Once started, a pulse runs its full width even if the request is cleared.
- R7: In either level mode, lwake_o stays active until the host clears the pending request.
- R8: A further wake event during a pulse, or while the request is still pending, neither restarts nor stretches the pulse.
- R9: bus_oe_o follows bus_drive_i only while iso_ni is 1, and is 0 while iso_ni is 0. The isolate input does not affect pme_drive_o.
- R10: When mode_we_i is high at a clock edge, mode_i is loaded into the stored mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_evt_i | input | 1 | Wake event strobe |
| clear_i | input | 1 | Host acknowledge, clears the pending request |
| mode_i | input | 2 | Wake output style to load |
| mode_we_i | input | 1 | Load strobe for mode_i |
| gate_iso_i | input | 1 | 1: wake output only while isolated |
| iso_ni | input | 1 | Isolate, active low (low = main power off) |
| bus_drive_i | input | 1 | Internal request to enable the host-bus drivers |
| pme_drive_o | output | 1 | Drive-low enable for the open-drain event request |
| lwake_o | output | 1 | LAN wake output |
| bus_oe_o | output | 1 | Host-bus driver enable, blocked while isolated |

## Verification
The bench builds the block with PULSE_CYCLES = 5. With that value the end of each pulse, and the pending cycles that follow it, can be observed within a few clocks. It also makes it possible to inject a second event inside a pulse and see that the width does not change, and to clear the request partway through a pulse. Every mode is visited through the load strobe. The gated case is driven through both isolate levels while a request is pending.

// File: rtl/wol_pkg.sv
package wol_pkg;
  typedef enum logic [1:0] {
    WK_LVL_HI  = 2'b00,
    WK_LVL_LO  = 2'b01,
    WK_PLS_POS = 2'b10,
    WK_PLS_NEG = 2'b11
  } wake_mode_e;

  function automatic logic mode_is_pulse(wake_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_idle_level(wake_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/wol_pend.sv
module wol_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (evt_i) pend_q <= 1'b1;  // event beats clear
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  AST_PEND_SET:  assert property (@(posedge clk_i) disable iff (!rst_ni) evt_i |=> pend_q); // R2
  AST_PEND_CLR:  assert property (@(posedge clk_i) disable iff (!rst_ni) (clr_i && !evt_i) |=> !pend_q); // R2
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (pend_q && !clr_i) |=> pend_q); // R7
endmodule

// File: rtl/wol_pulse.sv
module wol_pulse #(
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic pulse_o
);
  localparam int unsigned CntW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CntW-1:0] CntLoad = CntW'(PULSE_CYCLES - 1);

  logic [CntW-1:0] cnt_q;
  logic            armed_q;
  logic            start;

  // new pulse only on a fresh activation with no pulse running
  assign start   = act_i && !armed_q && (cnt_q == '0);
  assign pulse_o = start || (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= act_i;
      if (start)             cnt_q <= CntLoad;
      else if (cnt_q != '0)  cnt_q <= cnt_q - CntW'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= CntLoad); // R6
  AST_NO_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CntW'(1))); // R8
endmodule

// File: rtl/wol_wake_gen.sv
module wol_wake_gen #(
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wake_evt_i,
  input  logic       clear_i,
  input  logic [1:0] mode_i,
  input  logic       mode_we_i,
  input  logic       gate_iso_i,
  input  logic       iso_ni,
  input  logic       bus_drive_i,
  output logic       pme_drive_o,
  output logic       lwake_o,
  output logic       bus_oe_o
);
  import wol_pkg::*;

  wake_mode_e mode_q;
  logic       pend;
  logic       wake_act;
  logic       pulse_on;
  logic       active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= WK_LVL_HI;
    else if (mode_we_i) mode_q <= wake_mode_e'(mode_i);
  end

  wol_pend i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (wake_evt_i),
    .clr_i  (clear_i),
    .pend_o (pend)
  );

  assign wake_act = pend && (!gate_iso_i || !iso_ni);

  wol_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) i_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (wake_act && mode_is_pulse(mode_q)),
    .pulse_o (pulse_on)
  );

  assign active      = mode_is_pulse(mode_q) ? pulse_on : wake_act;
  assign lwake_o     = active ^ mode_idle_level(mode_q);
  assign pme_drive_o = pend;
  assign bus_oe_o    = bus_drive_i && iso_ni;  // request line exempt from isolation

  AST_UNGATED_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_iso_i && mode_q == WK_LVL_HI && pme_drive_o) |-> lwake_o); // R3
  AST_GATED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_iso_i && iso_ni && mode_q == WK_LVL_HI) |-> !lwake_o); // R4
  AST_LOW_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == WK_LVL_LO && !pme_drive_o) |-> lwake_o); // R5
  AST_ISO_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iso_ni |-> !bus_oe_o); // R9
endmodule

// File: tb/test_wol_wake_gen.sv
module test_wol_wake_gen;
  localparam int unsigned PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt = 0, clr = 0, mwe = 0, gate = 0, iso_n = 1, bdrv = 0;
  logic [1:0] mode = 2'b00;
  logic pme, lwake, boe;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic  pme;
    logic  wake;
    logic  oe;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  wol_wake_gen #(.PULSE_CYCLES(PW)) i_wol_wake_gen (
    .clk_i(clk), .rst_ni(rst_n), .wake_evt_i(evt), .clear_i(clr),
    .mode_i(mode), .mode_we_i(mwe), .gate_iso_i(gate), .iso_ni(iso_n),
    .bus_drive_i(bdrv), .pme_drive_o(pme), .lwake_o(lwake), .bus_oe_o(boe)
  );

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (pme !== e.pme || lwake !== e.wake || boe !== e.oe) begin
        n_bad++;
        $display("FAIL %s: pme/wake/oe = %b%b%b expected %b%b%b",
                 e.tag, pme, lwake, boe, e.pme, e.wake, e.oe);
      end
    end
  end

  // driver: set inputs for one edge and queue the result expected after it
  task automatic cyc(input logic e_i, input logic c_i, input logic xp, input logic xw,
                     input logic xo, input string tag);
    @(negedge clk);
    evt = e_i; clr = c_i;
    q.push_back('{xp, xw, xo, tag});
  endtask

  task automatic load_mode(input logic [1:0] m, input logic xw, input string tag);
    @(negedge clk);
    mode = m; mwe = 1; evt = 0; clr = 0;
    q.push_back('{1'b0, xw, 1'b0, tag});
    @(negedge clk);
    mwe = 0;
    q.push_back('{1'b0, xw, 1'b0, tag});
  endtask

  initial begin
    #10000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got incomplete expected complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    n_cmp++;
    if (pme !== 1'b0 || lwake !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: in reset pme/wake = %b%b expected 00", pme, lwake);
    end
    repeat (2) @(negedge clk);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, "R1");

    // R1 default mode = high level, R3 together with request, R7 held
    cyc(1, 0, 1, 1, 0, "R3");
    repeat (3) cyc(0, 0, 1, 1, 0, "R7");
    cyc(0, 1, 0, 0, 0, "R2 clear");
    cyc(1, 1, 1, 1, 0, "R2 event beats clear");
    cyc(0, 1, 0, 0, 0, "R2");

    // R5/R10 low level
    load_mode(2'b01, 1, "R10 low idle");
    cyc(1, 0, 1, 0, 0, "R5 low level");
    cyc(0, 0, 1, 0, 0, "R7 low level");
    cyc(0, 1, 0, 1, 0, "R7 low released");

    // positive pulse, retrigger inside pulse
    load_mode(2'b10, 0, "R10 pos idle");
    cyc(1, 0, 1, 1, 0, "R6 pulse start");
    cyc(0, 0, 1, 1, 0, "R6");
    cyc(1, 0, 1, 1, 0, "R8 event in pulse");
    cyc(0, 0, 1, 1, 0, "R6");
    cyc(0, 0, 1, 1, 0, "R6");
    cyc(0, 0, 1, 0, 0, "R8 no stretch");
    cyc(1, 0, 1, 0, 0, "R8 pending no repulse");
    cyc(0, 0, 1, 0, 0, "R6 done while pending");
    cyc(0, 1, 0, 0, 0, "R2");
    // clear partway through a pulse
    cyc(1, 0, 1, 1, 0, "R6 start");
    cyc(0, 1, 0, 1, 0, "R6 full width after clear");
    repeat (3) cyc(0, 0, 0, 1, 0, "R6 full width after clear");
    cyc(0, 0, 0, 0, 0, "R6 end");

    // negative pulse
    load_mode(2'b11, 1, "R10 neg idle");
    cyc(1, 0, 1, 0, 0, "R5 neg pulse");
    repeat (PW - 1) cyc(0, 0, 1, 0, 0, "R6 neg");
    cyc(0, 0, 1, 1, 0, "R6 neg end");
    cyc(0, 1, 0, 1, 0, "R2");

    // gated, high level
    load_mode(2'b00, 0, "R10 back to high");
    @(negedge clk); gate = 1; bdrv = 1;
    q.push_back('{1'b0, 1'b0, 1'b1, "R9 oe not isolated"});
    cyc(1, 0, 1, 0, 1, "R4 gated, not isolated");
    @(negedge clk); iso_n = 0; evt = 0;
    q.push_back('{1'b1, 1'b1, 1'b0, "R4/R9 isolated"});
    cyc(0, 0, 1, 1, 0, "R9 request kept in isolation");
    @(negedge clk); iso_n = 1;
    q.push_back('{1'b1, 1'b0, 1'b1, "R4 power back"});
    cyc(0, 1, 0, 0, 1, "R2");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule